// File: doc/BRIEF.md
# Selectable Pin Interrupt Unit

This block watches a wide bus of general-purpose input pins and produces up to eight independent interrupt requests. Each interrupt slot can be pointed at any pin of the bus. Each slot then works in one of two ways. In edge mode, a rising edge, a falling edge or either edge sets a status bit that stays set until software clears it. In level mode, the request follows the pin directly, active high or active low.

A separate group request watches the whole bus. Software picks which pins take part and the level each one must show. The group request fires when any enabled pin matches, or when every enabled pin matches, depending on one control bit. Every pin passes through a two-stage synchroniser before any of this logic sees it. The current synchronised level of any single pin can also be read back through the register port.

The register port has a write strobe with address and data, and a separate read address that returns data in the same cycle. The interrupt outputs go to an interrupt controller outside this block.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every slot request and the group request are low, and every configuration and status register reads zero.
- R2: Register address k (k = 0..7) holds the source pin index of slot k in bits [4:0]. Slot k reacts only to that pin, and any slot may select any pin.
- R3: A slot in edge mode (mode bit k = 0 at address 0x08) with its rise-enable bit set (bit k at 0x09) latches status on a rising edge of its pin. The request appears three clock edges after the pin changes.
- R4: A slot in edge mode with its fall-enable bit set (bit k at 0x0A) latches status on a falling edge. With both enables set, the slot latches on either edge.
- R5: An edge status bit (bit k at 0x0C, readable) stays set until a write to 0x0C with bit k equal to one. Writing zero to that bit, or writing ones to other bits, leaves it set.
- R6: When mode bit k is 1, slot k is in level mode. Its request is high while rise-enable bit k is set and the synchronised pin equals 1, or equals 0 when low-active bit k at 0x0B is set. The request follows the pin two edges after the pin changes, latches nothing and never sets status.
- R7: An edge-mode slot with both enables clear never latches status. A level-mode slot with rise-enable clear never requests.
- R8: Changing a slot's source pin index does not by itself latch status, even if the old pin and the new pin sit at different levels.
- R9: With group control (0x0F bit 0) at 0, the group request is high when any pin enabled at 0x0D shows the level given by its bit at 0x0E (1 = high, 0 = low).
- R10: With group control bit 0 at 1, the group request is high only when every enabled pin matches. It is low when no pin is enabled.
- R11: Reading address 0x40 + p returns the synchronised level of pin p in bit 0. The value reflects the pin two edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS (32) | Asynchronous general-purpose pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | DW (32) | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | DW (32) | Read data for rd_addr, same cycle |
| slot_irq | output | NSLOTS (8) | Per-slot interrupt requests |
| grp_irq | output | 1 | Group interrupt request |

## Verification
A wrong pin selection or a stuck edge detector shows up on the wrong bit of slot_irq exactly three edges after the pin toggles, so each test samples at that cycle and also checks the edges just before it. A status bit that clears too early or fails to latch can be seen both on slot_irq and in the status readback, right after the write that should or should not clear it. A false edge caused by re-pointing a slot would raise that slot's request within three cycles of the select write, and the tests watch for it. Faults in the group logic change grp_irq two edges after a pin moves, and the tests cover both combine modes, including the case where no pin is enabled.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
   localparam int unsigned ADDR_W = 7;

   localparam logic [ADDR_W-1:0] A_MODE     = 7'h08;
   localparam logic [ADDR_W-1:0] A_RISE     = 7'h09;
   localparam logic [ADDR_W-1:0] A_FALL     = 7'h0A;
   localparam logic [ADDR_W-1:0] A_LOW      = 7'h0B;
   localparam logic [ADDR_W-1:0] A_STAT     = 7'h0C;
   localparam logic [ADDR_W-1:0] A_GEN      = 7'h0D;
   localparam logic [ADDR_W-1:0] A_GPOL     = 7'h0E;
   localparam logic [ADDR_W-1:0] A_GCTL     = 7'h0F;
   localparam logic [ADDR_W-1:0] A_PIN_BASE = 7'h40;

   typedef enum logic {
      GRP_ANY = 1'b0,
      GRP_ALL = 1'b1
   } grp_comb_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("pin_irq_sync: STAGES must be 2..4");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];

   logic [2:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         age <= '0;
      else if (age != 3'd7) age <= age + 3'd1;
   end

   // R11
   sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'(STAGES)) |-> (dout == $past(din, STAGES)));
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned NSLOTS = 8,
   parameter int unsigned DW     = 32,
   parameter int unsigned IDXW   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic [NSLOTS-1:0] stat_i,
   input  logic [NPINS-1:0]  pin_s_i,
   output logic [IDXW-1:0]   sel_o [NSLOTS],
   output logic [NSLOTS-1:0] mode_o,
   output logic [NSLOTS-1:0] en_r_o,
   output logic [NSLOTS-1:0] en_f_o,
   output logic [NSLOTS-1:0] low_o,
   output logic [NPINS-1:0]  grp_en_o,
   output logic [NPINS-1:0]  grp_pol_o,
   output grp_comb_e         grp_comb_o,
   output logic [NSLOTS-1:0] stat_clr_o
);
   logic unused_wr;
   assign unused_wr = ^wr_data;

   for (genvar k = 0; k < NSLOTS; k++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sel_o[k] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(k))
            sel_o[k] <= wr_data[IDXW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o     <= '0;
         en_r_o     <= '0;
         en_f_o     <= '0;
         low_o      <= '0;
         grp_en_o   <= '0;
         grp_pol_o  <= '0;
         grp_comb_o <= GRP_ANY;
      end else if (wr_en) begin
         case (wr_addr)
            A_MODE: mode_o     <= wr_data[NSLOTS-1:0];
            A_RISE: en_r_o     <= wr_data[NSLOTS-1:0];
            A_FALL: en_f_o     <= wr_data[NSLOTS-1:0];
            A_LOW:  low_o      <= wr_data[NSLOTS-1:0];
            A_GEN:  grp_en_o   <= wr_data[NPINS-1:0];
            A_GPOL: grp_pol_o  <= wr_data[NPINS-1:0];
            A_GCTL: grp_comb_o <= grp_comb_e'(wr_data[0]);
            default: ;
         endcase
      end
   end

   assign stat_clr_o = (wr_en && wr_addr == A_STAT) ? wr_data[NSLOTS-1:0] : '0;

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NSLOTS; k++)
         if (rd_addr == ADDR_W'(k)) rd_data[IDXW-1:0] = sel_o[k];
      for (int p = 0; p < NPINS; p++)
         if (rd_addr == A_PIN_BASE + ADDR_W'(p)) rd_data[0] = pin_s_i[p];
      case (rd_addr)
         A_MODE: rd_data[NSLOTS-1:0] = mode_o;
         A_RISE: rd_data[NSLOTS-1:0] = en_r_o;
         A_FALL: rd_data[NSLOTS-1:0] = en_f_o;
         A_LOW:  rd_data[NSLOTS-1:0] = low_o;
         A_STAT: rd_data[NSLOTS-1:0] = stat_i;
         A_GEN:  rd_data[NPINS-1:0]  = grp_en_o;
         A_GPOL: rd_data[NPINS-1:0]  = grp_pol_o;
         A_GCTL: rd_data[0]          = grp_comb_o;
         default: ;
      endcase
   end
endmodule

// File: rtl/pin_irq_slot.sv
module pin_irq_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_mode_i,
   input  logic en_r_i,
   input  logic en_f_i,
   input  logic low_i,
   input  logic clr_i,
   input  logic rise_i,
   input  logic fall_i,
   input  logic lvl_i,
   output logic irq_o,
   output logic stat_o
);
   logic hit;
   assign hit = !lvl_mode_i && ((rise_i && en_r_i) || (fall_i && en_f_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stat_o <= 1'b0;
      else if (hit)   stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
   end

   assign irq_o = lvl_mode_i ? (en_r_i && (lvl_i != low_i)) : stat_o;

   // R5
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o && !clr_i) |=> stat_o);

   // R7
   no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_o && !en_r_i && !en_f_i) |=> !stat_o);

   // R3
   rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode_i && rise_i && en_r_i) |=> stat_o);
endmodule

// File: rtl/pin_irq_group.sv
module pin_irq_group
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic [NPINS-1:0] pin_s_i,
   input  logic [NPINS-1:0] en_i,
   input  logic [NPINS-1:0] pol_i,
   input  grp_comb_e        comb_i,
   output logic             irq_o
);
   logic [NPINS-1:0] match;
   logic             any_hit;
   logic             all_hit;

   assign match   = ~(pin_s_i ^ pol_i);
   assign any_hit = |(match & en_i);
   assign all_hit = (|en_i) && (&(match | ~en_i));
   assign irq_o   = (comb_i == GRP_ALL) ? all_hit : any_hit;
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned NSLOTS      = 8,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [6:0]        wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [6:0]        rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic [NSLOTS-1:0] slot_irq,
   output logic              grp_irq
);
   localparam int unsigned IDXW = $clog2(NPINS);

   if (NSLOTS < 1 || NSLOTS > 8) begin : g_bad_slots
      $error("pin_irq_unit: NSLOTS must be 1..8");
   end
   if (NPINS < 2 || NPINS > 64) begin : g_bad_pins
      $error("pin_irq_unit: NPINS must be 2..64");
   end
   if (NPINS > DW || NSLOTS > DW) begin : g_bad_dw
      $error("pin_irq_unit: DW too narrow");
   end

   logic [NPINS-1:0]  pin_s;
   logic [NPINS-1:0]  pin_p;
   logic [NPINS-1:0]  rise_v;
   logic [NPINS-1:0]  fall_v;
   logic [IDXW-1:0]   slot_sel [NSLOTS];
   logic [NSLOTS-1:0] mode, en_r, en_f, low, stat, stat_clr;
   logic [NPINS-1:0]  grp_en, grp_pol;
   grp_comb_e         grp_comb;

   pin_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_p <= '0;
      else        pin_p <= pin_s;
   end

   assign rise_v = pin_s & ~pin_p;
   assign fall_v = ~pin_s & pin_p;

   pin_irq_regs #(.NPINS(NPINS), .NSLOTS(NSLOTS), .DW(DW), .IDXW(IDXW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .stat_i    (stat),
      .pin_s_i   (pin_s),
      .sel_o     (slot_sel),
      .mode_o    (mode),
      .en_r_o    (en_r),
      .en_f_o    (en_f),
      .low_o     (low),
      .grp_en_o  (grp_en),
      .grp_pol_o (grp_pol),
      .grp_comb_o(grp_comb),
      .stat_clr_o(stat_clr)
   );

   for (genvar k = 0; k < NSLOTS; k++) begin : g_slot
      pin_irq_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl_mode_i(mode[k]),
         .en_r_i    (en_r[k]),
         .en_f_i    (en_f[k]),
         .low_i     (low[k]),
         .clr_i     (stat_clr[k]),
         .rise_i    (rise_v[slot_sel[k]]),
         .fall_i    (fall_v[slot_sel[k]]),
         .lvl_i     (pin_s[slot_sel[k]]),
         .irq_o     (slot_irq[k]),
         .stat_o    (stat[k])
      );
   end

   pin_irq_group #(.NPINS(NPINS)) u_group (
      .pin_s_i(pin_s),
      .en_i   (grp_en),
      .pol_i  (grp_pol),
      .comb_i (grp_comb),
      .irq_o  (grp_irq)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (slot_irq == '0 && !grp_irq));
endmodule

// File: tb/pin_irq_unit_tb.sv
module pin_irq_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_in = '0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [6:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  slot_irq;
   logic        grp_irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   pin_irq_unit u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .slot_irq(slot_irq),
      .grp_irq (grp_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      pin_in = '0;
      wr_en  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      check("R1 slot_irq", 32'(slot_irq), 0);
      check("R1 grp_irq", 32'(grp_irq), 0);
      rd(7'h03, v); check("R1 select reg", v, 0);
      rd(7'h08, v); check("R1 mode reg", v, 0);
      rd(7'h0C, v); check("R1 status reg", v, 0);
      rd(7'h0F, v); check("R1 group ctrl", v, 0);
   endtask

   task automatic t_route_rise();
      logic [31:0] v;
      do_reset();
      wr(7'h05, 17);
      wr(7'h02, 30);
      wr(7'h09, 32'h24);
      pin_in[17] = 1'b1;
      cyc(2);
      check("R3 not before third edge", 32'(slot_irq), 0);
      cyc(1);
      check("R2 R3 rise routed to slot 5 only", 32'(slot_irq), 32'h20);
      rd(7'h0C, v); check("R3 status readback", v, 32'h20);
   endtask

   task automatic t_fall_both();
      do_reset();
      wr(7'h01, 4);
      wr(7'h03, 9);
      wr(7'h0A, 32'h0A);
      wr(7'h09, 32'h08);
      pin_in[4] = 1'b1;
      pin_in[9] = 1'b1;
      cyc(3);
      check("R4 rise: only both-edge slot", 32'(slot_irq), 32'h08);
      wr(7'h0C, 32'h08);
      check("R5 clear slot 3", 32'(slot_irq), 0);
      pin_in[4] = 1'b0;
      pin_in[9] = 1'b0;
      cyc(3);
      check("R4 fall sets fall and both slots", 32'(slot_irq), 32'h0A);
   endtask

   task automatic t_sticky();
      logic [31:0] v;
      do_reset();
      wr(7'h00, 0);
      wr(7'h09, 32'h01);
      pin_in[0] = 1'b1;
      cyc(1);
      pin_in[0] = 1'b0;
      cyc(6);
      check("R5 sticky after pulse", 32'(slot_irq[0]), 1);
      wr(7'h0C, 32'h00);
      check("R5 zero write keeps", 32'(slot_irq[0]), 1);
      wr(7'h0C, 32'hFE);
      check("R5 other bits keep", 32'(slot_irq[0]), 1);
      wr(7'h0C, 32'h01);
      check("R5 one write clears", 32'(slot_irq), 0);
      rd(7'h0C, v); check("R5 status cleared", v, 0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      do_reset();
      wr(7'h06, 12);
      wr(7'h08, 32'h40);
      wr(7'h09, 32'h40);
      check("R6 high-active idle low", 32'(slot_irq), 0);
      pin_in[12] = 1'b1;
      cyc(1);
      check("R6 not after one edge", 32'(slot_irq), 0);
      cyc(1);
      check("R6 follows high", 32'(slot_irq), 32'h40);
      pin_in[12] = 1'b0;
      cyc(2);
      check("R6 no latch", 32'(slot_irq), 0);
      wr(7'h0B, 32'h40);
      check("R6 low-active", 32'(slot_irq), 32'h40);
      rd(7'h0C, v); check("R6 no status in level mode", v, 0);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      do_reset();
      wr(7'h04, 20);
      pin_in[20] = 1'b1;
      cyc(3);
      pin_in[20] = 1'b0;
      cyc(4);
      check("R7 edge disabled", 32'(slot_irq), 0);
      rd(7'h0C, v); check("R7 no status", v, 0);
      wr(7'h08, 32'h10);
      pin_in[20] = 1'b1;
      cyc(3);
      check("R7 level disabled", 32'(slot_irq), 0);
   endtask

   task automatic t_reselect();
      do_reset();
      pin_in[3] = 1'b1;
      cyc(5);
      wr(7'h07, 4);
      wr(7'h09, 32'h80);
      cyc(2);
      wr(7'h07, 3);
      cyc(4);
      check("R8 reselect no edge", 32'(slot_irq), 0);
      pin_in[3] = 1'b0;
      cyc(3);
      pin_in[3] = 1'b1;
      cyc(3);
      check("R8 R2 new pin edge", 32'(slot_irq), 32'h80);
   endtask

   task automatic t_grp_or();
      do_reset();
      wr(7'h0D, 32'h0000_0404);
      wr(7'h0E, 32'h0000_0004);
      check("R9 low-match pin 10", 32'(grp_irq), 1);
      pin_in[10] = 1'b1;
      cyc(2);
      check("R9 no match", 32'(grp_irq), 0);
      pin_in[5] = 1'b1;
      cyc(2);
      check("R9 disabled pin ignored", 32'(grp_irq), 0);
      pin_in[2] = 1'b1;
      cyc(2);
      check("R9 high-match pin 2", 32'(grp_irq), 1);
   endtask

   task automatic t_grp_and();
      do_reset();
      wr(7'h0F, 32'h1);
      check("R10 empty set", 32'(grp_irq), 0);
      wr(7'h0D, 32'h0000_0404);
      wr(7'h0E, 32'h0000_0404);
      pin_in[2] = 1'b1;
      cyc(2);
      check("R10 partial", 32'(grp_irq), 0);
      pin_in[10] = 1'b1;
      cyc(2);
      check("R10 all match", 32'(grp_irq), 1);
      pin_in[10] = 1'b0;
      cyc(2);
      check("R10 one drops", 32'(grp_irq), 0);
   endtask

   task automatic t_pin_read();
      logic [31:0] v;
      do_reset();
      pin_in[7]  = 1'b1;
      pin_in[31] = 1'b1;
      cyc(1);
      rd(7'h47, v); check("R11 not after one edge", v, 0);
      @(negedge clk);
      rd(7'h47, v); check("R11 pin 7", v, 1);
      rd(7'h5F, v); check("R11 pin 31", v, 1);
      rd(7'h48, v); check("R11 pin 8", v, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_route_rise();
      t_fall_both();
      t_sticky();
      t_level();
      t_disabled();
      t_reselect();
      t_grp_or();
      t_grp_and();
      t_pin_read();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule